// File: doc/BRIEF.md
# Transmit Packet Flush Controller

This block gathers outgoing bytes in a single packet buffer and decides when the buffer may go to the host. Three conditions can make a packet eligible. The first is a buffer holding the maximum packet size. The second is a programmable idle time in milliseconds since the last byte was written. The third is a falling edge on an external send-now strobe. The block does not hand over an eligible packet by itself. It holds the packet until the host side raises a bulk-in request, and then streams the bytes out in order on a read port, one byte per clock.

The strobe input has a second use while the link is suspended. If remote wakeup is enabled, a falling edge on the strobe produces a one-cycle resume request and does not release a packet. The millisecond time base comes from a prescaler whose division ratio is a parameter. The prescaler restarts on every accepted write, so the idle window is measured from the last byte.

Top module: `tx_flush_ctrl`

## Requirements
- R1: After reset, `pkt_ready_o`, `rd_valid_o` and `resume_o` are 0, `pkt_len_o` is 0 and `wr_ready_o` is 1.
- R2: A bulk request that arrives while `pkt_ready_o` is 1 starts the transfer. From the next cycle, `rd_valid_o` is 1 and the bytes appear on `rd_data_o` in write order, one per cycle. `rd_last_o` marks the final byte, and the byte count equals the `pkt_len_o` shown at the grant.
- R3: When the buffer holds MAX_PKT bytes (default 512), `pkt_ready_o` is 1 and `wr_ready_o` is 0. Further writes are refused and `pkt_len_o` stays at MAX_PKT.
- R4: With `timeout_ms_i` = T (1 to 255), a non-empty buffer becomes ready T×TICK_DIV cycles after the last accepted write. Every accepted write restarts that window.
- R5: A `timeout_ms_i` value of 0 selects the default window of DEF_TIMEOUT_MS (default 16) milliseconds.
- R6: When `suspend_i` is 0, a high-to-low transition on `siwu_ni` makes a non-empty buffer ready, whatever its byte count.
- R7: An empty buffer never shows `pkt_ready_o`. A bulk request made while no packet is ready starts no transfer.
- R8: With KEEP_EARLY_STROBE = 1 (default), a strobe that arrives while the buffer is empty is held. The buffer then becomes ready as soon as the next byte is written, and no packet appears before that byte.
- R9: When `suspend_i` and `wake_en_i` are both 1, each low pulse on `siwu_ni` gives exactly one single-cycle `resume_o` pulse and releases no packet.
- R10: When `suspend_i` is 1 and `wake_en_i` is 0, a strobe pulse gives no resume pulse and releases no packet.
- R11: While a packet is being streamed out, `wr_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Byte write request |
| wr_data_i | input | 8 | Byte to buffer |
| wr_ready_o | output | 1 | A write is accepted this cycle |
| timeout_ms_i | input | 8 | Idle timeout in ms; 0 selects the default |
| bulk_req_i | input | 1 | Host bulk-in request |
| pkt_ready_o | output | 1 | A packet is eligible for the next request |
| pkt_len_o | output | 10 | Bytes held in the buffer |
| rd_valid_o | output | 1 | Packet byte valid |
| rd_data_o | output | 8 | Packet byte |
| rd_last_o | output | 1 | Final byte of the packet |
| siwu_ni | input | 1 | Send-now / wakeup strobe, active low, asynchronous |
| suspend_i | input | 1 | Link is suspended |
| wake_en_i | input | 1 | Remote wakeup allowed |
| resume_o | output | 1 | One-cycle resume request |

## Verification
Each release path is tested on its own, with the other two held off.

- A 3-byte packet is released only by the strobe, which shows that the strobe ignores the byte count.
- A full 512-byte packet is released only by size, and an extra write is attempted to confirm the refusal.
- Two timed packets are released only by idle time. One uses a programmed window with a write part way through to show that the window restarts. The other uses the zero code to select the default.

The strobe is also sent in three more situations: on an empty buffer, while suspended with wakeup enabled, and while suspended with wakeup disabled. These runs separate the three outcomes: a deferred flush, a resume pulse, and no effect at all. Every released packet is read back in full and compared byte by byte against what was written.

// File: rtl/tx_flush_pkg.sv
package tx_flush_pkg;
  typedef enum logic {ST_FILL = 1'b0, ST_SEND = 1'b1} tx_state_e;
endpackage

// File: rtl/ms_tick.sv
module ms_tick #(
  parameter int DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign tick_o = wrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || wrap)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_ni};
  end

  // previous synced level high, current low
  assign fall_o = sh_q[STAGES] && !sh_q[STAGES-1];
endmodule

// File: rtl/pkt_buf.sv
module pkt_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 512
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_flush_ctrl.sv
module tx_flush_ctrl
  import tx_flush_pkg::*;
#(
  parameter int DATA_W            = 8,
  parameter int MAX_PKT           = 512,
  parameter int TICK_DIV          = 125000,
  parameter int DEF_TIMEOUT_MS    = 16,
  parameter int KEEP_EARLY_STROBE = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_valid_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic                         wr_ready_o,
  input  logic [7:0]                   timeout_ms_i,
  input  logic                         bulk_req_i,
  output logic                         pkt_ready_o,
  output logic [$clog2(MAX_PKT+1)-1:0] pkt_len_o,
  output logic                         rd_valid_o,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic                         rd_last_o,
  input  logic                         siwu_ni,
  input  logic                         suspend_i,
  input  logic                         wake_en_i,
  output logic                         resume_o
);
  localparam int LEN_W = $clog2(MAX_PKT + 1);
  localparam int AW    = $clog2(MAX_PKT);

  tx_state_e      state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [AW-1:0]  rd_ptr_q;
  logic [7:0]     idle_ms_q;
  logic           flush_q, early_q, resume_q;

  logic           wr_acc, full, send_start, timer_run, tick_clr, tick, fall, flush_req;
  logic [7:0]     limit;

  assign full        = (cnt_q == LEN_W'(MAX_PKT));
  assign wr_ready_o  = (state_q == ST_FILL) && !full;
  assign wr_acc      = wr_valid_i && wr_ready_o;
  assign pkt_ready_o = (state_q == ST_FILL) && (cnt_q != '0) && (flush_q || full);
  assign send_start  = pkt_ready_o && bulk_req_i;
  assign rd_valid_o  = (state_q == ST_SEND);
  assign rd_last_o   = rd_valid_o && ((LEN_W'(rd_ptr_q) + 1'b1) == cnt_q);
  assign pkt_len_o   = cnt_q;
  assign resume_o    = resume_q;

  assign limit     = (timeout_ms_i == 8'd0) ? 8'(DEF_TIMEOUT_MS) : timeout_ms_i;
  assign timer_run = (state_q == ST_FILL) && (cnt_q != '0) && !flush_q && !full;
  assign tick_clr  = wr_acc || !timer_run;
  assign flush_req = fall && !suspend_i;

  ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tick_clr), .tick_o(tick)
  );

  strobe_edge #(.STAGES(2)) u_strobe (
    .clk_i (clk_i), .rst_ni(rst_ni), .strobe_ni(siwu_ni), .fall_o(fall)
  );

  pkt_buf #(.DW(DATA_W), .DEPTH(MAX_PKT)) u_buf (
    .clk_i  (clk_i),
    .we_i   (wr_acc),
    .waddr_i(cnt_q[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr_q),
    .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FILL;
      cnt_q     <= '0;
      rd_ptr_q  <= '0;
      idle_ms_q <= '0;
      flush_q   <= 1'b0;
      early_q   <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      resume_q <= fall && suspend_i && wake_en_i;
      unique case (state_q)
        ST_FILL: begin
          if (wr_acc) begin
            cnt_q <= cnt_q + 1'b1;
            if (early_q) begin
              flush_q <= 1'b1;
              early_q <= 1'b0;
            end
          end
          if (flush_req) begin
            if (cnt_q != '0 || wr_acc)            flush_q <= 1'b1;
            else if (KEEP_EARLY_STROBE != 0)      early_q <= 1'b1;
          end
          if (tick_clr) idle_ms_q <= '0;
          else if (tick) begin
            if (({1'b0, idle_ms_q} + 9'd1) >= {1'b0, limit}) flush_q <= 1'b1;
            else idle_ms_q <= idle_ms_q + 1'b1;
          end
          if (send_start) begin
            state_q  <= ST_SEND;
            rd_ptr_q <= '0;
          end
        end
        ST_SEND: begin
          rd_ptr_q <= rd_ptr_q + 1'b1;
          if (rd_last_o) begin
            state_q   <= ST_FILL;
            cnt_q     <= '0;
            flush_q   <= 1'b0;
            idle_ms_q <= '0;
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/tx_flush_ctrl_chk.sv
module tx_flush_ctrl_chk #(
  parameter int MAX_PKT = 512
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_ready_o,
  input logic                         bulk_req_i,
  input logic                         pkt_ready_o,
  input logic [$clog2(MAX_PKT+1)-1:0] pkt_len_o,
  input logic                         rd_valid_o,
  input logic                         rd_last_o,
  input logic                         suspend_i,
  input logic                         wake_en_i,
  input logic                         resume_o
);
  assert_send_after_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(pkt_ready_o && bulk_req_i));

  assert_last_ends_send_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_last_o) |=> !rd_valid_o);

  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_len_o <= ($clog2(MAX_PKT+1))'(MAX_PKT));

  assert_full_refuses_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_len_o == ($clog2(MAX_PKT+1))'(MAX_PKT)) |-> !wr_ready_o);

  assert_no_empty_pkt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_ready_o |-> (pkt_len_o != '0));

  assert_resume_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  assert_resume_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(suspend_i && wake_en_i));

  assert_no_wr_in_send_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !wr_ready_o);
endmodule

bind tx_flush_ctrl tx_flush_ctrl_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_ready_o (wr_ready_o),
  .bulk_req_i (bulk_req_i),
  .pkt_ready_o(pkt_ready_o),
  .pkt_len_o  (pkt_len_o),
  .rd_valid_o (rd_valid_o),
  .rd_last_o  (rd_last_o),
  .suspend_i  (suspend_i),
  .wake_en_i  (wake_en_i),
  .resume_o   (resume_o)
);

// File: tb/tx_flush_ctrl_test.sv
module tx_flush_ctrl_test;
  localparam int MAX_PKT = 512;
  localparam int DIV     = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       wr_ready_o;
  logic [7:0] timeout_ms_i = 8'd255;
  logic       bulk_req_i = 1'b0;
  logic       pkt_ready_o;
  logic [9:0] pkt_len_o;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;
  logic       rd_last_o;
  logic       siwu_ni = 1'b1;
  logic       suspend_i = 1'b0;
  logic       wake_en_i = 1'b0;
  logic       resume_o;

  int checks = 0;
  int fails = 0;
  int resume_cnt = 0;

  always #4 clk_i = ~clk_i;

  tx_flush_ctrl #(.MAX_PKT(MAX_PKT), .TICK_DIV(DIV)) uut (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .wr_ready_o, .timeout_ms_i,
    .bulk_req_i, .pkt_ready_o, .pkt_len_o, .rd_valid_o, .rd_data_o, .rd_last_o,
    .siwu_ni, .suspend_i, .wake_en_i, .resume_o
  );

  always @(negedge clk_i) if (rst_ni && resume_o) resume_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic write_bytes(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      wr_valid_i = 1'b1;
      wr_data_i  = 8'(base + i);
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk_i) siwu_ni = 1'b0;
    wait_cyc(3);
    siwu_ni = 1'b1;
    wait_cyc(3);
  endtask

  task automatic read_pkt(input int n, input logic [7:0] base, input string req);
    int bad = 0;
    int act = 0;
    int exp = 0;
    @(negedge clk_i) bulk_req_i = 1'b1;
    @(negedge clk_i) bulk_req_i = 1'b0;
    chk(wr_ready_o == 1'b0, "R11 writes refused while sending", int'(wr_ready_o), 0);
    for (int i = 0; i < n; i++) begin
      if (!rd_valid_o || rd_data_o != 8'(base + i) || rd_last_o != (i == n - 1)) begin
        if (bad == 0) begin
          act = int'(rd_data_o);
          exp = int'(8'(base + i));
        end
        bad++;
      end
      @(negedge clk_i);
    end
    chk(bad == 0, {req, " bytes in order with last flag"}, act, exp);
    chk(rd_valid_o == 1'b0 && pkt_len_o == 0, {req, " transfer ends, buffer empty"},
        int'(pkt_len_o), 0);
  endtask

  task automatic t_reset();
    chk(!pkt_ready_o && !rd_valid_o && !resume_o && pkt_len_o == 0 && wr_ready_o,
        "R1 reset state", int'({pkt_ready_o, rd_valid_o, resume_o, wr_ready_o}), 1);
  endtask

  task automatic t_bulk_empty();
    bit seen = 1'b0;
    @(negedge clk_i) bulk_req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (rd_valid_o || pkt_ready_o) seen = 1'b1;
    end
    bulk_req_i = 1'b0;
    chk(!seen, "R7 request on empty buffer starts nothing", int'(seen), 0);
  endtask

  task automatic t_strobe_flush();
    write_bytes(3, 8'h40);
    wait_cyc(4);
    chk(!pkt_ready_o, "R6 no packet before strobe", int'(pkt_ready_o), 0);
    strobe();
    chk(pkt_ready_o && pkt_len_o == 3, "R6 strobe releases short packet",
        int'(pkt_len_o), 3);
    read_pkt(3, 8'h40, "R2");
  endtask

  task automatic t_full();
    write_bytes(MAX_PKT, 8'h10);
    chk(pkt_ready_o && !wr_ready_o && pkt_len_o == 10'(MAX_PKT), "R3 full buffer ready",
        int'(pkt_len_o), MAX_PKT);
    write_bytes(1, 8'hEE);
    chk(pkt_len_o == 10'(MAX_PKT), "R3 write to full buffer refused", int'(pkt_len_o), MAX_PKT);
    read_pkt(MAX_PKT, 8'h10, "R3");
  endtask

  task automatic t_timeout_prog();
    timeout_ms_i = 8'd3;
    write_bytes(2, 8'h70);
    wait_cyc(40);
    chk(!pkt_ready_o, "R4 not ready before window", int'(pkt_ready_o), 0);
    write_bytes(1, 8'h72);
    wait_cyc(55);
    chk(!pkt_ready_o, "R4 window restarted by write", int'(pkt_ready_o), 0);
    wait_cyc(8);
    chk(pkt_ready_o && pkt_len_o == 3, "R4 ready after 3 ms idle", int'(pkt_ready_o), 1);
    read_pkt(3, 8'h70, "R4");
  endtask

  task automatic t_timeout_default();
    timeout_ms_i = 8'd0;
    write_bytes(1, 8'h99);
    wait_cyc(16 * DIV - 5);
    chk(!pkt_ready_o, "R5 not ready before 16 ms", int'(pkt_ready_o), 0);
    wait_cyc(8);
    chk(pkt_ready_o, "R5 ready after default 16 ms", int'(pkt_ready_o), 1);
    read_pkt(1, 8'h99, "R5");
    timeout_ms_i = 8'd255;
  endtask

  task automatic t_early_strobe();
    strobe();
    wait_cyc(3);
    chk(!pkt_ready_o && pkt_len_o == 0, "R7 strobe on empty gives no packet",
        int'(pkt_ready_o), 0);
    write_bytes(1, 8'h55);
    wait_cyc(1);
    chk(pkt_ready_o && pkt_len_o == 1, "R8 held strobe flushes next byte",
        int'(pkt_ready_o), 1);
    read_pkt(1, 8'h55, "R8");
  endtask

  task automatic t_wakeup();
    int base_cnt;
    write_bytes(1, 8'hA0);
    suspend_i = 1'b1;
    wake_en_i = 1'b1;
    base_cnt  = resume_cnt;
    strobe();
    wait_cyc(2);
    chk(resume_cnt == base_cnt + 1, "R9 one resume pulse", resume_cnt - base_cnt, 1);
    chk(!pkt_ready_o, "R9 no flush while suspended", int'(pkt_ready_o), 0);
    wake_en_i = 1'b0;
    strobe();
    wait_cyc(2);
    chk(resume_cnt == base_cnt + 1 && !pkt_ready_o, "R10 strobe ignored when wake disabled",
        resume_cnt - base_cnt, 1);
    suspend_i = 1'b0;
    wait_cyc(2);
    strobe();
    chk(pkt_ready_o && pkt_len_o == 1, "R6 strobe flushes after resume",
        int'(pkt_ready_o), 1);
    read_pkt(1, 8'hA0, "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_bulk_empty();
    t_strobe_flush();
    t_full();
    t_timeout_prog();
    t_timeout_default();
    t_early_strobe();
    t_wakeup();
    wait_cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule